// File: doc/BRIEF.md
# Byte and Bit Execute Unit

This block is the execute stage of a small 8-bit accumulator processor with 12-bit instruction words. Each transfer gives it one instruction word, the current working register (W), the operand byte already read from the register file at the instruction's file address, and the current status flags. One cycle later it returns the computed byte, where that byte goes (W or the file register), whether any write happens at all, the next status flags, and a request to skip the following instruction.

It handles byte-wide file operations (add, subtract, logic, increment/decrement, complement, move, rotate through carry, nibble swap, clear), single-bit set/clear/test on a file register, and the logic and move operations against an 8-bit literal. Branches, calls, returns, sleep and watchdog control are outside its scope: those encodings come out as a no-operation, and the sequencer handles them.

Both sides are valid/ready streams. An instruction is taken on a rising clock edge where `in_valid` and `in_ready` are both high. The result is held in a single output register. `in_ready` is high when that register is empty or is being drained in the same cycle, so back-pressure from `out_ready` stalls the input side with no lost or duplicated results. While `out_valid` is high and `out_ready` is low, every output field holds its value.

Top module: `byte_bit_exec`

## Requirements
- R1: `in_ready` is high when the output register is empty or `out_ready` is high. An accepted instruction's result shows with `out_valid` high on the next clock. While `out_valid` is high and `out_ready` is low, all output fields hold steady.
- R2: For byte-file instructions (bits 11:6 opcode, bit 5 = d, bits 4:0 = file address), d=1 sends the result to the file register (`out_to_file`=1, `out_faddr` = bits 4:0), and d=0 sends it to W.
- R3: Add (000111) computes f+W. Subtract (000010) computes f+~W+1. Both set C (flag bit 0) to the carry out of bit 7 (C=1 means no borrow on subtract), DC (flag bit 1) to the carry out of bit 3, and Z (flag bit 2) to result==0.
- R4: Rotate-left (001101) gives {f[6:0],C} with C set to f[7]. Rotate-right (001100) gives {C,f[7:1]} with C set to f[0]. Only C changes.
- R5: AND 000101, OR 000100, XOR 000110, complement 001001, increment 001010, decrement 000011 and move-f 001000 update only Z. Nibble swap (001110) exchanges the two nibbles of f and changes no flag.
- R6: 0000011fffff clears file register f and sets Z. 000001000000 clears W and sets Z. 0000001fffff writes W to file register f with no flag change.
- R7: Bit ops use bits 11:8 as opcode, bits 7:5 as bit index and bits 4:0 as file address. 0100 clears and 0101 sets the indexed bit and writes back to the file. No bit op changes a flag.
- R8: Decrement-skip (001011) and increment-skip (001111) write like their plain forms, change no flag, and request a skip when the result is zero. Test-clear (0110) requests a skip when the indexed bit is 0, test-set (0111) when it is 1. Neither test writes.
- R9: Literal ops (bits 11:8 opcode, bits 7:0 = k) always write W. 1110 gives W&k, 1101 gives W|k and 1111 gives W^k, each updating only Z. 1100 loads k with no flag change.
- R10: Any other encoding (including 000000000000, 000001 with d=0 and a nonzero address, and 1000-1011) gives `out_wr_en`=0, `out_skip`=0 and `out_flags` equal to `in_flags`.
- R11: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction bundle present |
| in_ready | output | 1 | Block can take a bundle this cycle |
| in_instr | input | 12 | Instruction word |
| in_wreg | input | 8 | Current W |
| in_fdata | input | 8 | Operand read from the file register |
| in_flags | input | 3 | Current flags: bit 0 C, bit 1 DC, bit 2 Z |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_valid | output | 1 | Result present |
| out_result | output | 8 | Computed byte |
| out_to_file | output | 1 | 1: destination is file register, 0: W |
| out_wr_en | output | 1 | Destination must be written |
| out_faddr | output | 5 | File address for the write |
| out_flags | output | 3 | Next flags, same bit order as `in_flags` |
| out_skip | output | 1 | Skip the following instruction |

## Verification
The only internal state is the output register and its valid bit, so a fault shows at the ports within one clock of the instruction that exposes it. A dropped or doubled valid shows up as a missing or extra result in the ordered stream under back-pressure. A bad decode or flag merge shows up as a wrong destination, write enable, flag or skip on that instruction's own result. The stimulus therefore pairs carry, half-carry and zero corner values for every flag-updating opcode with stalled output cycles, so ordering and holding are checked together.

// File: rtl/exec_pkg.sv
package exec_pkg;

  localparam int EX_DATA_W  = 8;
  localparam int EX_INSTR_W = 12;
  localparam int EX_FADDR_W = 5;
  localparam int EX_BIDX_W  = 3;
  localparam int EX_FLAG_W  = 3;

  localparam int FLG_C  = 0;
  localparam int FLG_DC = 1;
  localparam int FLG_Z  = 2;

  typedef enum logic [3:0] {
    FN_PASSF, FN_PASSB, FN_ADD, FN_SUB, FN_AND, FN_IOR, FN_XOR, FN_COM,
    FN_INC, FN_DEC, FN_RLF, FN_RRF, FN_SWAP, FN_ZERO, FN_BCLR, FN_BSET
  } alu_fn_e;

  typedef enum logic [1:0] {
    SK_NONE, SK_ZERO, SK_BITCLR, SK_BITSET
  } skip_e;

  typedef struct packed {
    alu_fn_e                 fn;
    logic                    use_lit;
    logic                    to_file;
    logic                    wr;
    logic [EX_FLAG_W-1:0]    upd;
    skip_e                   skip_kind;
    logic [EX_BIDX_W-1:0]    bit_idx;
    logic [EX_FADDR_W-1:0]   faddr;
    logic [EX_DATA_W-1:0]    lit;
  } dec_t;

endpackage

// File: rtl/exec_decode.sv
module exec_decode
  import exec_pkg::*;
(
  input  logic [EX_INSTR_W-1:0] instr,
  output dec_t                  dec
);

  localparam logic [EX_FLAG_W-1:0] UPD_NONE = 3'b000;
  localparam logic [EX_FLAG_W-1:0] UPD_Z    = 3'b100;
  localparam logic [EX_FLAG_W-1:0] UPD_C    = 3'b001;
  localparam logic [EX_FLAG_W-1:0] UPD_ALL  = 3'b111;

  logic [1:0] grp;
  logic [1:0] sub;
  logic [5:0] op6;
  logic       dbit;

  assign grp  = instr[11:10];
  assign sub  = instr[9:8];
  assign op6  = instr[11:6];
  assign dbit = instr[5];

  always_comb begin
    dec           = '0;
    dec.fn        = FN_PASSF;
    dec.skip_kind = SK_NONE;
    dec.upd       = UPD_NONE;
    dec.to_file   = dbit;
    dec.bit_idx   = instr[7:5];
    dec.faddr     = instr[4:0];
    dec.lit       = instr[7:0];
    unique case (grp)
      2'b11: begin
        dec.use_lit = 1'b1;
        dec.wr      = 1'b1;
        dec.to_file = 1'b0;
        unique case (sub)
          2'b00: dec.fn = FN_PASSB;
          2'b01: begin dec.fn = FN_IOR; dec.upd = UPD_Z; end
          2'b10: begin dec.fn = FN_AND; dec.upd = UPD_Z; end
          default: begin dec.fn = FN_XOR; dec.upd = UPD_Z; end
        endcase
      end
      2'b01: begin
        dec.to_file = 1'b1;
        unique case (sub)
          2'b00: begin dec.fn = FN_BCLR; dec.wr = 1'b1; end
          2'b01: begin dec.fn = FN_BSET; dec.wr = 1'b1; end
          2'b10: dec.skip_kind = SK_BITCLR;
          default: dec.skip_kind = SK_BITSET;
        endcase
      end
      2'b00: begin
        unique case (op6)
          6'b000000: begin
            if (dbit) begin
              dec.fn = FN_PASSB;
              dec.wr = 1'b1;
            end
          end
          6'b000001: begin
            if (dbit) begin
              dec.fn  = FN_ZERO;
              dec.wr  = 1'b1;
              dec.upd = UPD_Z;
            end else if (instr[4:0] == '0) begin
              dec.fn  = FN_ZERO;
              dec.wr  = 1'b1;
              dec.upd = UPD_Z;
            end
          end
          6'b000010: begin dec.fn = FN_SUB;   dec.wr = 1'b1; dec.upd = UPD_ALL; end
          6'b000011: begin dec.fn = FN_DEC;   dec.wr = 1'b1; dec.upd = UPD_Z;   end
          6'b000100: begin dec.fn = FN_IOR;   dec.wr = 1'b1; dec.upd = UPD_Z;   end
          6'b000101: begin dec.fn = FN_AND;   dec.wr = 1'b1; dec.upd = UPD_Z;   end
          6'b000110: begin dec.fn = FN_XOR;   dec.wr = 1'b1; dec.upd = UPD_Z;   end
          6'b000111: begin dec.fn = FN_ADD;   dec.wr = 1'b1; dec.upd = UPD_ALL; end
          6'b001000: begin dec.fn = FN_PASSF; dec.wr = 1'b1; dec.upd = UPD_Z;   end
          6'b001001: begin dec.fn = FN_COM;   dec.wr = 1'b1; dec.upd = UPD_Z;   end
          6'b001010: begin dec.fn = FN_INC;   dec.wr = 1'b1; dec.upd = UPD_Z;   end
          6'b001011: begin dec.fn = FN_DEC;   dec.wr = 1'b1; dec.skip_kind = SK_ZERO; end
          6'b001100: begin dec.fn = FN_RRF;   dec.wr = 1'b1; dec.upd = UPD_C;   end
          6'b001101: begin dec.fn = FN_RLF;   dec.wr = 1'b1; dec.upd = UPD_C;   end
          6'b001110: begin dec.fn = FN_SWAP;  dec.wr = 1'b1; end
          default:   begin dec.fn = FN_INC;   dec.wr = 1'b1; dec.skip_kind = SK_ZERO; end
        endcase
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/exec_alu.sv
module exec_alu #(
  parameter int DATA_W = 8,
  parameter int BIDX_W = 3
) (
  input  exec_pkg::alu_fn_e  fn,
  input  logic [DATA_W-1:0]  opa,
  input  logic [DATA_W-1:0]  opb,
  input  logic [BIDX_W-1:0]  bit_idx,
  input  logic               cin,
  output logic [DATA_W-1:0]  result,
  output logic               cout,
  output logic               dcout,
  output logic               zero,
  output logic               bit_val
);
  import exec_pkg::*;

  localparam int NIB = DATA_W / 2;

  logic [DATA_W-1:0] bmask;
  logic [DATA_W-1:0] addend;
  logic              add_cin;
  logic [DATA_W:0]   sum_full;
  logic [NIB:0]      sum_low;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign bmask[i] = (bit_idx == BIDX_W'(i));
  end

  assign bit_val  = |(opa & bmask);
  assign addend   = (fn == FN_SUB) ? ~opb : opb;
  assign add_cin  = (fn == FN_SUB);
  assign sum_full = {1'b0, opa} + {1'b0, addend} + {{DATA_W{1'b0}}, add_cin};
  assign sum_low  = {1'b0, opa[NIB-1:0]} + {1'b0, addend[NIB-1:0]} + {{NIB{1'b0}}, add_cin};

  always_comb begin
    result = opa;
    cout   = cin;
    dcout  = sum_low[NIB];
    unique case (fn)
      FN_PASSF: result = opa;
      FN_PASSB: result = opb;
      FN_ADD, FN_SUB: begin
        result = sum_full[DATA_W-1:0];
        cout   = sum_full[DATA_W];
      end
      FN_AND:  result = opa & opb;
      FN_IOR:  result = opa | opb;
      FN_XOR:  result = opa ^ opb;
      FN_COM:  result = ~opa;
      FN_INC:  result = opa + 1'b1;
      FN_DEC:  result = opa - 1'b1;
      FN_RLF: begin
        result = {opa[DATA_W-2:0], cin};
        cout   = opa[DATA_W-1];
      end
      FN_RRF: begin
        result = {cin, opa[DATA_W-1:1]};
        cout   = opa[0];
      end
      FN_SWAP: result = {opa[NIB-1:0], opa[DATA_W-1:NIB]};
      FN_ZERO: result = '0;
      FN_BCLR: result = opa & ~bmask;
      default: result = opa | bmask;
    endcase
  end

  assign zero = (result == '0);

endmodule

// File: rtl/exec_outreg.sv
module exec_outreg #(
  parameter int PAY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic [PAY_W-1:0] up_data,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic [PAY_W-1:0] dn_data
);

  logic             full_q;
  logic [PAY_W-1:0] data_q;

  assign up_ready = !full_q || dn_ready;
  assign dn_valid = full_q;
  assign dn_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (up_ready) full_q <= up_valid;
      if (up_valid && up_ready) data_q <= up_data;
    end
  end

endmodule

// File: rtl/byte_bit_exec.sv
module byte_bit_exec
  import exec_pkg::*;
#(
  parameter int DATA_W  = EX_DATA_W,
  parameter int INSTR_W = EX_INSTR_W,
  parameter int FADDR_W = EX_FADDR_W,
  parameter int FLAG_W  = EX_FLAG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [INSTR_W-1:0] in_instr,
  input  logic [DATA_W-1:0]  in_wreg,
  input  logic [DATA_W-1:0]  in_fdata,
  input  logic [FLAG_W-1:0]  in_flags,
  input  logic               out_ready,
  output logic               out_valid,
  output logic [DATA_W-1:0]  out_result,
  output logic               out_to_file,
  output logic               out_wr_en,
  output logic [FADDR_W-1:0] out_faddr,
  output logic [FLAG_W-1:0]  out_flags,
  output logic               out_skip
);

  localparam int PAY_W = DATA_W + 2 + FADDR_W + FLAG_W + 1;

  dec_t              dec;
  logic [DATA_W-1:0] opa, opb, res;
  logic              c_n, dc_n, z_n, bv;
  logic [FLAG_W-1:0] calc_flags, next_flags;
  logic              skip_n;
  logic [PAY_W-1:0]  pay_in, pay_out;

  exec_decode u_dec (
    .instr (in_instr),
    .dec   (dec)
  );

  assign opa = dec.use_lit ? in_wreg : in_fdata;
  assign opb = dec.use_lit ? dec.lit : in_wreg;

  exec_alu #(.DATA_W(DATA_W), .BIDX_W(EX_BIDX_W)) u_alu (
    .fn      (dec.fn),
    .opa     (opa),
    .opb     (opb),
    .bit_idx (dec.bit_idx),
    .cin     (in_flags[FLG_C]),
    .result  (res),
    .cout    (c_n),
    .dcout   (dc_n),
    .zero    (z_n),
    .bit_val (bv)
  );

  assign calc_flags[FLG_C]  = c_n;
  assign calc_flags[FLG_DC] = dc_n;
  assign calc_flags[FLG_Z]  = z_n;

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    assign next_flags[i] = dec.upd[i] ? calc_flags[i] : in_flags[i];
  end

  always_comb begin
    unique case (dec.skip_kind)
      SK_ZERO:   skip_n = z_n;
      SK_BITCLR: skip_n = !bv;
      SK_BITSET: skip_n = bv;
      default:   skip_n = 1'b0;
    endcase
  end

  assign pay_in = {res, dec.to_file, dec.wr, dec.faddr, next_flags, skip_n};

  exec_outreg #(.PAY_W(PAY_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (pay_in),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (pay_out)
  );

  assign {out_result, out_to_file, out_wr_en, out_faddr, out_flags, out_skip} = pay_out;

endmodule

// File: rtl/byte_bit_exec_checker.sv
module byte_bit_exec_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [11:0] in_instr,
  input logic [2:0]  in_flags,
  input logic        out_ready,
  input logic        out_valid,
  input logic [7:0]  out_result,
  input logic        out_to_file,
  input logic        out_wr_en,
  input logic [2:0]  out_flags,
  input logic        out_skip
);

  logic take;
  assign take = in_valid && in_ready;

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
      $stable(out_flags) && $stable(out_skip) && $stable(out_wr_en) && $stable(out_to_file)));

  assert_clear_file_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_instr[11:5] == 7'b0000011) |=> (out_result == 8'h00 && out_flags[2] && out_to_file && out_wr_en));

  assert_bitop_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_instr[11:10] == 2'b01) |=> (out_flags == $past(in_flags)));

  assert_test_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_instr[11:9] == 3'b011) |=> !out_wr_en);

  assert_literal_dest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_instr[11:10] == 2'b11) |=> (out_wr_en && !out_to_file && !out_skip));

endmodule

bind byte_bit_exec byte_bit_exec_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_instr    (in_instr),
  .in_flags    (in_flags),
  .out_ready   (out_ready),
  .out_valid   (out_valid),
  .out_result  (out_result),
  .out_to_file (out_to_file),
  .out_wr_en   (out_wr_en),
  .out_flags   (out_flags),
  .out_skip    (out_skip)
);

// File: tb/byte_bit_exec_test.sv
`timescale 1ns/1ps
module byte_bit_exec_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_instr = '0;
  logic [7:0]  in_wreg = '0;
  logic [7:0]  in_fdata = '0;
  logic [2:0]  in_flags = '0;
  logic        out_ready = 1'b1;
  logic        out_valid;
  logic [7:0]  out_result;
  logic        out_to_file;
  logic        out_wr_en;
  logic [4:0]  out_faddr;
  logic [2:0]  out_flags;
  logic        out_skip;

  always #2.5 clk = ~clk;

  byte_bit_exec uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_wreg(in_wreg), .in_fdata(in_fdata), .in_flags(in_flags),
    .out_ready(out_ready), .out_valid(out_valid), .out_result(out_result),
    .out_to_file(out_to_file), .out_wr_en(out_wr_en), .out_faddr(out_faddr),
    .out_flags(out_flags), .out_skip(out_skip)
  );

  typedef struct {
    logic [7:0] res;
    logic       tofile;
    logic       wr;
    logic [4:0] fa;
    logic [2:0] fl;
    logic       sk;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  bit   bp = 0;
  bit   done = 0;
  bit   stall_seen = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  // Expected behaviour, written from the requirement text.
  function automatic exp_t model(input logic [11:0] ins, input int w, input int f, input logic [2:0] fl);
    exp_t e;
    int r; int c; int dc; int bi; int k;
    e.res = 0; e.tofile = 0; e.wr = 0; e.fa = ins[4:0]; e.fl = fl; e.sk = 0;
    c = fl[0]; bi = ins[7:5]; k = ins[7:0];
    if (ins[11:10] == 2'b11) begin                         // R9
      e.wr = 1; e.tofile = 0;
      case (ins[9:8])
        2'b00: r = k;
        2'b01: r = w | k;
        2'b10: r = w & k;
        default: r = w ^ k;
      endcase
      e.res = r[7:0];
      if (ins[9:8] != 2'b00) e.fl[2] = (e.res == 0);
    end else if (ins[11:10] == 2'b01) begin                // R7, R8
      e.tofile = 1;
      case (ins[9:8])
        2'b00: begin e.wr = 1; e.res = f[7:0] & ~(8'd1 << bi); end
        2'b01: begin e.wr = 1; e.res = f[7:0] | (8'd1 << bi); end
        2'b10: e.sk = ((f >> bi) & 1) == 0;
        default: e.sk = ((f >> bi) & 1) == 1;
      endcase
    end else if (ins[11:10] == 2'b00) begin
      e.tofile = ins[5]; e.wr = 1;
      case (ins[11:6])
        6'b000000: begin if (ins[5]) e.res = w[7:0]; else e.wr = 0; end
        6'b000001: begin
          if (ins[5] || ins[4:0] == 0) begin e.res = 0; e.fl[2] = 1; end
          else e.wr = 0;
        end
        6'b000111, 6'b000010: begin
          int addend;
          int cin;
          addend = (ins[11:6] == 6'b000111) ? w : (~w & 255);
          cin = (ins[11:6] == 6'b000111) ? 0 : 1;
          r = f + addend + cin;
          dc = (f & 15) + (addend & 15) + cin;
          e.res = r[7:0];
          e.fl = {e.res == 0, dc > 15, r > 255};
        end
        6'b000101: begin e.res = f & w; e.fl[2] = (e.res == 0); end
        6'b000100: begin e.res = f | w; e.fl[2] = (e.res == 0); end
        6'b000110: begin e.res = f ^ w; e.fl[2] = (e.res == 0); end
        6'b001001: begin e.res = ~f; e.fl[2] = (e.res == 0); end
        6'b001010: begin e.res = f + 1; e.fl[2] = (e.res == 0); end
        6'b000011: begin e.res = f - 1; e.fl[2] = (e.res == 0); end
        6'b001000: begin e.res = f; e.fl[2] = (e.res == 0); end
        6'b001011: begin e.res = f - 1; e.sk = (e.res == 0); end
        6'b001111: begin e.res = f + 1; e.sk = (e.res == 0); end
        6'b001101: begin e.res = (f * 2 + c) & 255; e.fl[0] = (f >= 128); end
        6'b001100: begin e.res = (f / 2) + c * 128; e.fl[0] = f[0]; end
        default:   begin e.res = ((f & 15) * 16) + (f / 16); end
      endcase
    end
    return e;
  endfunction

  task automatic step();
    @(negedge clk);
    cyc++;
    out_ready = bp ? (cyc % 3 != 0) : 1'b1;
  endtask

  task automatic send(input logic [11:0] ins, input int w, input int f, input logic [2:0] fl, input string tag);
    exp_t e;
    e = model(ins, w, f, fl);
    e.tag = tag;
    step();
    in_valid = 1; in_instr = ins; in_wreg = w[7:0]; in_fdata = f[7:0]; in_flags = fl;
    #1;
    while (!in_ready) begin step(); #1; end
    q.push_back(e);
    if (!bp) begin step(); in_valid = 0; end
  endtask

  // Monitor: compares each transferred result against the queue head.
  initial begin
    logic [7:0] held;
    forever begin
      @(negedge clk); #1;
      if (rst_n && out_valid && !out_ready) begin
        stall_seen = 1;
        held = out_result;
        @(negedge clk); #1;
        check(out_valid && out_result == held, "R1", "hold under stall", out_result, held);
      end
      if (rst_n && out_valid && out_ready) begin
        if (q.size() == 0) check(0, "R1", "unexpected result", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          check(out_wr_en == e.wr, e.tag, "wr_en", out_wr_en, e.wr);
          if (e.wr) begin
            check(out_to_file == e.tofile, e.tag, "dest", out_to_file, e.tofile);
            check(out_result == e.res, e.tag, "result", out_result, e.res);
            if (e.tofile) check(out_faddr == e.fa, e.tag, "faddr", out_faddr, e.fa);
          end
          check(out_flags == e.fl, e.tag, "flags", out_flags, e.fl);
          check(out_skip == e.sk, e.tag, "skip", out_skip, e.sk);
        end
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_all();
    send(12'b000111_1_00011, 8'h08, 8'hF8, 3'b000, "R3");  // add wraps to 0: C DC Z
    send(12'b000111_0_00011, 8'h11, 8'h22, 3'b111, "R3");  // add, no carries, to W
    send(12'b000010_1_00100, 8'h05, 8'h05, 3'b000, "R3");  // sub equal: C=1 DC=1 Z=1
    send(12'b000010_0_00100, 8'h05, 8'h03, 3'b111, "R3");  // sub borrow: 0xFE C=0 DC=0
    send(12'b001101_1_00101, 8'h00, 8'h81, 3'b000, "R4");  // rlf C=0
    send(12'b001101_0_00101, 8'h00, 8'h40, 3'b111, "R4");  // rlf C=1 in
    send(12'b001100_1_00110, 8'h00, 8'h01, 3'b110, "R4");  // rrf to 0, Z kept
    send(12'b001100_0_00110, 8'h00, 8'h02, 3'b001, "R4");
    send(12'b000101_0_00111, 8'hF0, 8'h0F, 3'b011, "R5");  // and -> 0, Z
    send(12'b000100_1_01000, 8'hA0, 8'h05, 3'b100, "R5");
    send(12'b000110_0_01000, 8'h5A, 8'h5A, 3'b000, "R5");
    send(12'b001001_1_01001, 8'h00, 8'hFF, 3'b011, "R5");
    send(12'b001010_0_01010, 8'h00, 8'hFF, 3'b000, "R5");  // inc wraps
    send(12'b000011_1_01011, 8'h00, 8'h00, 3'b100, "R5");  // dec wraps
    send(12'b001000_0_01100, 8'h00, 8'h00, 3'b011, "R5");
    send(12'b001110_1_01101, 8'h00, 8'h3C, 3'b010, "R5");  // swap
    send(12'b001110_0_01101, 8'h00, 8'h00, 3'b101, "R2");
    send(12'b000001_1_11111, 8'h33, 8'h77, 3'b011, "R6");  // clear file
    send(12'b000001_0_00000, 8'h33, 8'h77, 3'b000, "R6");  // clear W
    send(12'b000000_1_10101, 8'hC3, 8'h00, 3'b111, "R6");  // W to file
    send(12'b0100_111_10000, 8'h00, 8'hFF, 3'b101, "R7");  // clear bit 7
    send(12'b0101_000_10001, 8'h00, 8'h00, 3'b010, "R7");  // set bit 0
    send(12'b0101_011_10001, 8'h00, 8'h80, 3'b000, "R7");
    send(12'b001011_1_00001, 8'h00, 8'h01, 3'b000, "R8");  // decfsz -> skip
    send(12'b001011_0_00001, 8'h00, 8'h02, 3'b100, "R8");
    send(12'b001111_1_00001, 8'h00, 8'hFF, 3'b011, "R8");  // incfsz -> skip
    send(12'b0110_010_00010, 8'h00, 8'hFB, 3'b000, "R8");  // test bit2 clear -> skip
    send(12'b0110_010_00010, 8'h00, 8'h04, 3'b000, "R8");
    send(12'b0111_110_00010, 8'h00, 8'h40, 3'b111, "R8");  // test bit6 set -> skip
    send(12'b0111_110_00010, 8'h00, 8'hBF, 3'b111, "R8");
    send(12'b1110_00001111, 8'hF0, 8'h00, 3'b000, "R9");   // and literal -> 0
    send(12'b1101_10000001, 8'h02, 8'h00, 3'b100, "R9");
    send(12'b1111_11111111, 8'hFF, 8'h00, 3'b000, "R9");
    send(12'b1100_00000000, 8'h55, 8'h00, 3'b011, "R9");   // load literal, flags kept
    send(12'b000000000000, 8'h55, 8'h66, 3'b101, "R10");
    send(12'b000001000001, 8'h55, 8'h66, 3'b010, "R10");
    send(12'b101000000111, 8'h55, 8'h66, 3'b111, "R10");
    send(12'b100100000001, 8'h00, 8'h00, 3'b001, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R11", "out_valid in reset", out_valid, 0);
    check(in_ready == 1, "R11", "in_ready in reset", in_ready, 1);
    rst_n = 1;
    run_all();
    bp = 1;
    run_all();
    step(); in_valid = 0;
    bp = 0;
    repeat (20) step();
    check(q.size() == 0, "R1", "results drained", q.size(), 0);
    check(stall_seen, "R1", "stall exercised", stall_seen, 1);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule